// File: doc/BRIEF.md
# Serial-Input Systematic LDPC Encoder

This block turns a stream of message bits, arriving one per clock on a single data pin, into 12-bit systematic codewords for a storage channel. It collects nine bits into a message. It appends three parity bits formed by AND/XOR logic from a fixed low-density generator, and places the word on a parallel bus together with a one-cycle valid strobe.

A collect enable gates the serial input. Bits are taken only on clock edges where the enable is high, so a sender can pause in the middle of a message without losing what it has already sent. Once the ninth bit is in, the finished message is copied into a holding register. The shift register is then free at once, so the next message can start on the very next clock with no idle cycles between messages.

The parity set is chosen so that each message bit feeds exactly two of the three checks:

| Check | Message bits |
|-------|--------------|
| p0 | m0–m5 |
| p1 | m0–m2 and m6–m8 |
| p2 | m3–m8 |

Top module: `ldpc_serial_encoder`

## Requirements
- R1: A synchronous active-high `rst` clears the bit counter, any partial message, the output word (to 0) and the valid strobe. After reset, the next accepted bit is treated as m0 of a new message.
- R2: `sdin` is sampled on a rising clock edge only when `collect_en` is high. The first bit accepted after reset or after a completed message becomes m0, and the ninth becomes m8.
- R3: The codeword layout is `cw_out[11:3]` = m8..m0 (m8 at bit 11, m0 at bit 3) and `cw_out[2:0]` = p2,p1,p0 (p0 at bit 0).
- R4: The parity bits are p0 = m0^m1^m2^m3^m4^m5, p1 = m0^m1^m2^m6^m7^m8 and p2 = m3^m4^m5^m6^m7^m8.
- R5: `cw_valid` is high for exactly one cycle. It rises on the rising edge that follows the edge on which the ninth bit was accepted, and it never pulses otherwise.
- R6: The first bit of the next message may be presented on the cycle right after the ninth bit of the previous one. Back-to-back messages then produce a codeword every nine cycles with no loss.
- R7: While `collect_en` is low, the bit counter and the partial message hold, and `sdin` is ignored.
- R8: `cw_out` holds its last codeword until the next `cw_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising-edge active |
| rst | input | 1 | Synchronous active-high reset |
| collect_en | input | 1 | Accept `sdin` on this edge when high |
| sdin | input | 1 | Serial message bit |
| cw_out | output | 12 | Codeword {m8..m0, p2..p0} |
| cw_valid | output | 1 | One-cycle strobe marking a new codeword |

## Verification
The bench applies all 512 messages back to back. A buffer that stalls or drops the first bit of the following message would shift every later codeword and miss its due cycle. A second pass pauses `collect_en` at irregular points and drives inverted garbage on `sdin` during the pauses. A counter that advanced or sampled during a pause would yield codewords with wrong message bits or parity. A reset applied in the middle of a message must discard the partial bits; a design that kept them would produce a word mixing old and new bits. Every cycle without a strobe is also checked for a steady output and for a missing pulse on the cycle one is due.

// File: rtl/ldpc_enc_pkg.sv
package ldpc_enc_pkg;
    localparam int MSG_BITS = 9;
    localparam int PAR_BITS = 3;
    // One MSG_BITS slice per parity bit, p0 in the lowest slice.
    localparam logic [PAR_BITS*MSG_BITS-1:0] GEN_COLS = {9'h1F8, 9'h1C7, 9'h03F};
endpackage

// File: rtl/ldpc_ser_collect.sv
module ldpc_ser_collect #(
    parameter int MSG_W = 9,
    localparam int CNT_W = $clog2(MSG_W + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             collect_en,
    input  logic             sdin,
    output logic [MSG_W-1:0] msg_word,
    output logic             msg_ready,
    output logic [CNT_W-1:0] bit_cnt
);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(MSG_W - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [MSG_W-2:0] shreg;
        logic [MSG_W-1:0] hold;
        logic             ready;
    } col_st_t;

    col_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.ready = 1'b0;
        if (collect_en) begin
            if (st_q.cnt == LAST_IDX) begin
                st_d.hold  = {sdin, st_q.shreg};
                st_d.ready = 1'b1;
                st_d.cnt   = '0;
            end else begin
                st_d.shreg = {sdin, st_q.shreg[MSG_W-2:1]};
                st_d.cnt   = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign msg_word  = st_q.hold;
    assign msg_ready = st_q.ready;
    assign bit_cnt   = st_q.cnt;
endmodule

// File: rtl/ldpc_parity_net.sv
module ldpc_parity_net #(
    parameter int MSG_W = 9,
    parameter int PAR_W = 3,
    parameter logic [PAR_W*MSG_W-1:0] COLS = '0
) (
    input  logic [MSG_W-1:0] msg,
    output logic [PAR_W-1:0] par
);
    for (genvar j = 0; j < PAR_W; j++) begin : g_chk
        assign par[j] = ^(msg & COLS[j*MSG_W +: MSG_W]);
    end
endmodule

// File: rtl/ldpc_serial_encoder.sv
module ldpc_serial_encoder
    import ldpc_enc_pkg::*;
#(
    parameter int MSG_W = MSG_BITS,
    parameter int PAR_W = PAR_BITS,
    parameter logic [PAR_W*MSG_W-1:0] COLS = GEN_COLS,
    localparam int CW_W  = MSG_W + PAR_W,
    localparam int CNT_W = $clog2(MSG_W + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            collect_en,
    input  logic            sdin,
    output logic [CW_W-1:0] cw_out,
    output logic            cw_valid
);
    logic [MSG_W-1:0] held_msg;
    logic             launch;
    logic [CNT_W-1:0] msg_cnt;
    logic [PAR_W-1:0] par_bits;

    ldpc_ser_collect #(.MSG_W(MSG_W)) u_col (
        .clk        (clk),
        .rst        (rst),
        .collect_en (collect_en),
        .sdin       (sdin),
        .msg_word   (held_msg),
        .msg_ready  (launch),
        .bit_cnt    (msg_cnt)
    );

    ldpc_parity_net #(.MSG_W(MSG_W), .PAR_W(PAR_W), .COLS(COLS)) u_par (
        .msg (held_msg),
        .par (par_bits)
    );

    typedef struct packed {
        logic [CW_W-1:0] cw;
        logic            vld;
    } out_st_t;

    out_st_t out_d, out_q;

    always_comb begin
        out_d     = out_q;
        out_d.vld = launch;
        if (launch) begin
            out_d.cw = {held_msg, par_bits};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign cw_out   = out_q.cw;
    assign cw_valid = out_q.vld;
endmodule

// File: rtl/ldpc_serial_encoder_chk.sv
module ldpc_serial_encoder_chk #(
    parameter int MSG_W = 9,
    parameter int PAR_W = 3,
    parameter logic [PAR_W*MSG_W-1:0] COLS = '0,
    localparam int CW_W  = MSG_W + PAR_W,
    localparam int CNT_W = $clog2(MSG_W + 1)
) (
    input logic            clk,
    input logic            rst,
    input logic            collect_en,
    input logic [CW_W-1:0] cw_out,
    input logic            cw_valid,
    input logic [CNT_W-1:0] msg_cnt,
    input logic            launch
);
    logic [PAR_W-1:0] syn;
    for (genvar j = 0; j < PAR_W; j++) begin : g_syn
        assign syn[j] = (^(cw_out[CW_W-1:PAR_W] & COLS[j*MSG_W +: MSG_W])) ^ cw_out[j];
    end

    // R5
    vld_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        cw_valid |=> !cw_valid);

    // R5
    vld_follow_chk: assert property (@(posedge clk) disable iff (rst)
        launch |=> cw_valid);

    // R5
    vld_cause_chk: assert property (@(posedge clk) disable iff (rst)
        cw_valid |-> $past(launch));

    // R8
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cw_valid |-> $stable(cw_out));

    // R7
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !collect_en |=> $stable(msg_cnt));

    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        msg_cnt < CNT_W'(MSG_W));

    // R4
    parity_ok_chk: assert property (@(posedge clk) disable iff (rst)
        cw_valid |-> (syn == '0));
endmodule

bind ldpc_serial_encoder ldpc_serial_encoder_chk #(
    .MSG_W(MSG_W), .PAR_W(PAR_W), .COLS(COLS)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .collect_en (collect_en),
    .cw_out     (cw_out),
    .cw_valid   (cw_valid),
    .msg_cnt    (msg_cnt),
    .launch     (launch)
);

// File: tb/sim_ldpc_serial_encoder.sv
`timescale 1ns/1ps
module sim_ldpc_serial_encoder;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        collect_en = 1'b0;
    logic        sdin = 1'b0;
    logic [11:0] cw_out;
    logic        cw_valid;

    int n_checks = 0;
    int n_fails  = 0;
    int cyc      = 0;
    bit done     = 1'b0;

    logic [11:0] exp_q[$];
    int          due_q[$];
    logic [8:0]  mdl_msg;
    int          mdl_cnt = 0;
    logic [11:0] last_cw = '0;
    int          gap_k = 0;

    always #2.5 clk = ~clk;

    ldpc_serial_encoder u0 (
        .clk(clk), .rst(rst), .collect_en(collect_en), .sdin(sdin),
        .cw_out(cw_out), .cw_valid(cw_valid)
    );

    function automatic logic [11:0] enc(input logic [8:0] m);
        logic p0, p1, p2;
        p0 = m[0] ^ m[1] ^ m[2] ^ m[3] ^ m[4] ^ m[5];
        p1 = m[0] ^ m[1] ^ m[2] ^ m[6] ^ m[7] ^ m[8];
        p2 = m[3] ^ m[4] ^ m[5] ^ m[6] ^ m[7] ^ m[8];
        return {m, p2, p1, p0};
    endfunction

    task automatic monitor(input string tag);
        if (cw_valid) begin
            n_checks++;
            if (exp_q.size() == 0 || due_q[0] != cyc) begin
                n_fails++;
                $display("FAIL R5 (%s): unexpected pulse at cycle %0d, act cw=%h exp no pulse", tag, cyc, cw_out);
            end else begin
                logic [11:0] e;
                e = exp_q.pop_front();
                void'(due_q.pop_front());
                if (cw_out !== e) begin
                    n_fails++;
                    $display("FAIL R3 R4 (%s): act %h exp %h", tag, cw_out, e);
                end
            end
            last_cw = cw_out;
        end else begin
            n_checks++;
            if (exp_q.size() != 0 && due_q[0] == cyc) begin
                n_fails++;
                $display("FAIL R5 (%s): missing pulse at cycle %0d, act 0 exp 1", tag, cyc);
                void'(exp_q.pop_front());
                void'(due_q.pop_front());
            end
            if (cw_out !== last_cw) begin
                n_fails++;
                $display("FAIL R8 (%s): output moved without pulse, act %h exp %h", tag, cw_out, last_cw);
            end
        end
    endtask

    task automatic step(input logic e, input logic d, input string tag);
        @(negedge clk);
        cyc++;
        monitor(tag);
        collect_en = e;
        sdin       = d;
        if (e) begin
            mdl_msg[mdl_cnt] = d;
            if (mdl_cnt == 8) begin
                exp_q.push_back(enc(mdl_msg));
                due_q.push_back(cyc + 2);
                mdl_cnt = 0;
            end else begin
                mdl_cnt++;
            end
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        cyc++;
        rst = 1'b1; collect_en = 1'b0; sdin = 1'b0;
        repeat (3) begin @(negedge clk); cyc++; end
        rst = 1'b0;
        exp_q.delete(); due_q.delete();
        mdl_cnt = 0; last_cw = '0;
        @(negedge clk);
        cyc++;
        n_checks++;
        if (cw_out !== 12'h000 || cw_valid !== 1'b0) begin
            n_fails++;
            $display("FAIL R1: after reset act cw=%h vld=%b exp cw=000 vld=0", cw_out, cw_valid);
        end
    endtask

    task automatic send_msg(input logic [8:0] m, input bit gappy, input string tag);
        for (int b = 0; b < 9; b++) begin
            if (gappy) begin
                while ((gap_k % 4) == 1 || (gap_k % 7) == 3) begin
                    step(1'b0, ~m[b], tag);
                    gap_k++;
                end
                gap_k++;
            end
            step(1'b1, m[b], tag);
        end
    endtask

    initial begin
        do_reset();
        // R6, R3, R4: all messages back to back
        for (int m = 0; m < 512; m++) send_msg(9'(m), 1'b0, "R6");
        repeat (4) step(1'b0, 1'b1, "R5");
        // R7, R2: pauses with garbage on the data pin
        for (int i = 0; i < 40; i++) send_msg(9'((i * 37 + 5) % 512), 1'b1, "R7");
        repeat (4) step(1'b0, 1'b0, "R7");
        // R1: partial message discarded by reset
        for (int b = 0; b < 5; b++) step(1'b1, 1'b1, "R1");
        do_reset();
        send_msg(9'h0A5, 1'b0, "R1");
        send_msg(9'h15A, 1'b0, "R2");
        repeat (5) step(1'b0, 1'b0, "R5");
        n_checks++;
        if (exp_q.size() != 0) begin
            n_fails++;
            $display("FAIL R5: pending codewords act %0d exp 0", exp_q.size());
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: act hung exp finished");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end
endmodule